// File: doc/BRIEF.md
# Consecutive MAC Address Generator

This block turns a small configuration image into a block of consecutive Ethernet MAC addresses. After reset it reads seven bytes, one at a time, through a byte-read request/acknowledge port. The first six bytes form the base address and the seventh is the number of addresses assigned to the board. Once all seven bytes are held, the block raises `ready` and answers index queries. Each answer is the base address with its last octet advanced by the index.

The block also reports two conditions about the stored image. The first is an unprogrammed image, where every base byte reads as 0xFF. The second is a range whose last octet would roll past 0xFF. Out-of-range queries return zero and raise an error output. The block sits between a storage reader, which serves the byte requests, and the logic that assigns addresses to network ports.

Top module: `mac_range_expander`

## Requirements
- R1: The fetch reads image addresses 0,1,2,3,4,5,6 in that order. Only one request is open at a time. `rd_req` and `rd_addr` stay unchanged until `rd_ack` is seen high at a clock edge, and `rd_addr` never exceeds 6 while a request is open.
- R2: The bytes returned for addresses 0 to 5 form the base address, most significant octet first (address 0 lands in bits 47:40). The byte at address 6 is the address count.
- R3: `ready` is low until the edge that captures the byte for address 6. It is high from that edge on and never falls until reset. No read request is raised while `ready` is high.
- R4: A query (`q_valid` high with `ready` high) is answered at the next clock edge with `mac_valid` high for one cycle. When `q_index` is less than the count, `mac_out` holds the top 40 bits of the base unchanged and a low octet of (base low octet + `q_index`) modulo 256.
- R5: When `q_index` is greater than or equal to the count, the answer has `mac_out` all zeros and `idx_err` high. This includes every index when the count is 0.
- R6: `unprog` is high while `ready` is high and all 48 base bits are ones. Otherwise it is low.
- R7: `wrap` is high while `ready` is high, the count is nonzero and (base low octet + count - 1) exceeds 0xFF. Otherwise it is low.
- R8: A query made while `ready` is low is ignored. `mac_valid` and `idx_err` are low the following cycle.
- R9: `unprog` and `wrap` are low while `ready` is low, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; restarts the fetch |
| rd_req | output | 1 | Byte read request, held until acknowledged |
| rd_addr | output | 3 | Image byte address of the open request |
| rd_ack | input | 1 | Read response strobe, one cycle |
| rd_data | input | 8 | Byte returned with `rd_ack` |
| q_valid | input | 1 | Index query strobe |
| q_index | input | 8 | Index of the requested address |
| ready | output | 1 | All seven image bytes captured |
| mac_valid | output | 1 | Query answer valid, one cycle |
| mac_out | output | 48 | Generated address, or zero on error |
| idx_err | output | 1 | Queried index not below the count |
| unprog | output | 1 | Base reads as all ones |
| wrap | output | 1 | Range rolls the low octet past 0xFF |

## Verification
The storage model drives `rd_ack` and `rd_data` at a falling edge after a random delay of 0 to 3 cycles. It checks the address at that moment, while the open request is still held. `ready` and both flags become visible one rising edge after the seventh acknowledge, so the bench looks at them at the falling edge that follows. A query is applied at a falling edge, and the answer registers at the next rising edge. The bench therefore checks `mac_valid`, `mac_out` and `idx_err` exactly one falling edge later, including queries made before `ready`.

// File: rtl/mac_exp_pkg.sv
package mac_exp_pkg;
    localparam int BYTE_W    = 8;
    localparam int MAC_OCTS  = 6;

    typedef enum logic {
        ST_FETCH = 1'b0,
        ST_READY = 1'b1
    } fetch_st_e;
endpackage

// File: rtl/mac_fetch_seq.sv
module mac_fetch_seq
    import mac_exp_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int NB = MAC_OCTS,
    localparam int NF = NB + 1,
    localparam int AW = $clog2(NF),
    localparam int MW = NB * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          done,
    output logic [MW-1:0] base,
    output logic [DW-1:0] count
);
    typedef struct packed {
        fetch_st_e     st;
        logic [AW-1:0] ptr;
        logic [MW-1:0] base;
        logic [DW-1:0] cnt;
    } fs_t;

    fs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.st == ST_FETCH && rd_ack) begin
            if (s_q.ptr < AW'(NB)) begin
                s_d.base[MW-1-int'(s_q.ptr)*DW -: DW] = rd_data;
            end else begin
                s_d.cnt = rd_data;
            end
            if (s_q.ptr == AW'(NF-1)) begin
                s_d.st = ST_READY;
            end else begin
                s_d.ptr = s_q.ptr + AW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_FETCH, ptr: '0, base: '0, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_req  = (s_q.st == ST_FETCH);
    assign rd_addr = s_q.ptr;
    assign done    = (s_q.st == ST_READY);
    assign base    = s_q.base;
    assign count   = s_q.cnt;
endmodule

// File: rtl/mac_flag_eval.sv
module mac_flag_eval
    import mac_exp_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int NB = MAC_OCTS,
    localparam int MW = NB * DW
) (
    input  logic          done,
    input  logic [MW-1:0] base,
    input  logic [DW-1:0] count,
    output logic          unprog,
    output logic          wrap
);
    logic [DW:0] span_end;

    always_comb begin
        span_end = {1'b0, base[DW-1:0]} + {1'b0, count} - (DW+1)'(1);
        unprog   = done && (&base);
        wrap     = done && (|count) && span_end[DW];
    end
endmodule

// File: rtl/mac_query_unit.sv
module mac_query_unit
    import mac_exp_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int NB = MAC_OCTS,
    localparam int MW = NB * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ready,
    input  logic          q_valid,
    input  logic [DW-1:0] q_index,
    input  logic [MW-1:0] base,
    input  logic [DW-1:0] count,
    output logic          mac_valid,
    output logic [MW-1:0] mac_out,
    output logic          idx_err
);
    typedef struct packed {
        logic          vld;
        logic          err;
        logic [MW-1:0] mac;
    } qa_t;

    qa_t a_d, a_q;

    always_comb begin
        a_d = '{vld: 1'b0, err: 1'b0, mac: '0};
        if (ready && q_valid) begin
            a_d.vld = 1'b1;
            if (q_index < count) begin
                a_d.mac = {base[MW-1:DW], base[DW-1:0] + q_index};
            end else begin
                a_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '{vld: 1'b0, err: 1'b0, mac: '0};
        end else begin
            a_q <= a_d;
        end
    end

    assign mac_valid = a_q.vld;
    assign mac_out   = a_q.mac;
    assign idx_err   = a_q.err;
endmodule

// File: rtl/mac_range_expander.sv
module mac_range_expander
    import mac_exp_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int NB = MAC_OCTS,
    localparam int AW = $clog2(NB + 1),
    localparam int MW = NB * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    input  logic          q_valid,
    input  logic [DW-1:0] q_index,
    output logic          ready,
    output logic          mac_valid,
    output logic [MW-1:0] mac_out,
    output logic          idx_err,
    output logic          unprog,
    output logic          wrap
);
    logic [MW-1:0] base_w;
    logic [DW-1:0] count_w;

    mac_fetch_seq #(.DW(DW), .NB(NB)) u_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (rd_req),
        .rd_addr (rd_addr),
        .rd_ack  (rd_ack),
        .rd_data (rd_data),
        .done    (ready),
        .base    (base_w),
        .count   (count_w)
    );

    mac_flag_eval #(.DW(DW), .NB(NB)) u_flags (
        .done   (ready),
        .base   (base_w),
        .count  (count_w),
        .unprog (unprog),
        .wrap   (wrap)
    );

    mac_query_unit #(.DW(DW), .NB(NB)) u_query (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready     (ready),
        .q_valid   (q_valid),
        .q_index   (q_index),
        .base      (base_w),
        .count     (count_w),
        .mac_valid (mac_valid),
        .mac_out   (mac_out),
        .idx_err   (idx_err)
    );
endmodule

// File: rtl/mac_range_expander_chk.sv
module mac_range_expander_chk
    import mac_exp_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int NB = MAC_OCTS,
    localparam int NF = NB + 1,
    localparam int AW = $clog2(NF),
    localparam int MW = NB * DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic          rd_ack,
    input logic          q_valid,
    input logic          ready,
    input logic          mac_valid,
    input logic [MW-1:0] mac_out,
    input logic          idx_err,
    input logic          unprog,
    input logic          wrap
);
    // R1
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    // R1
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (int'(rd_addr) < NF));

    // R3
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R3
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !rd_req);

    // R4
    answer_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && ready) |=> mac_valid);

    // R5
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_err |-> (mac_valid && mac_out == '0));

    // R8
    early_query_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && !ready) |=> (!mac_valid && !idx_err));

    // R9
    flags_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (!unprog && !wrap));
endmodule

bind mac_range_expander mac_range_expander_chk #(.DW(DW), .NB(NB)) u_chk (.*);

// File: tb/sim_mac_range_expander.sv
module sim_mac_range_expander;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req;
    logic [2:0]  rd_addr;
    logic        rd_ack = 1'b0;
    logic [7:0]  rd_data = '0;
    logic        q_valid = 1'b0;
    logic [7:0]  q_index = '0;
    logic        ready, mac_valid, idx_err, unprog, wrap;
    logic [47:0] mac_out;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] img [7];
    int wait_cnt = 0;
    int exp_addr = 0;

    always #2 clk = ~clk;

    mac_range_expander u0 (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .q_valid(q_valid), .q_index(q_index),
        .ready(ready), .mac_valid(mac_valid), .mac_out(mac_out), .idx_err(idx_err),
        .unprog(unprog), .wrap(wrap)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Storage model: answers each open request after 0..3 cycles
    always @(negedge clk) begin
        rd_ack = 1'b0;
        if (rst_n && rd_req) begin
            if (wait_cnt == 0) begin
                chk(rd_addr == 3'(exp_addr), "R1", "fetch address", 64'(rd_addr), 64'(exp_addr));
                chk(!ready, "R3", "ready during fetch", 64'(ready), 64'd0);
                chk(!unprog && !wrap, "R9", "flags during fetch", {62'd0, unprog, wrap}, 64'd0);
                rd_ack   = 1'b1;
                rd_data  = img[rd_addr];
                exp_addr = exp_addr + 1;
                wait_cnt = $urandom_range(0, 3);
            end else begin
                wait_cnt = wait_cnt - 1;
            end
        end
    end

    function automatic logic [47:0] exp_mac(input logic [47:0] b, input logic [7:0] c,
                                            input logic [7:0] i);
        return (i < c) ? {b[47:8], 8'(b[7:0] + i)} : 48'd0;
    endfunction

    function automatic logic [47:0] img_base();
        return {img[0], img[1], img[2], img[3], img[4], img[5]};
    endfunction

    task automatic load(input logic [47:0] b, input logic [7:0] c, input bit early_q);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 6; i++) img[i] = b[47-8*i -: 8];
        img[6] = c;
        exp_addr = 0;
        wait_cnt = 2;
        repeat (2) @(negedge clk);
        chk(!ready && !mac_valid && !unprog && !wrap && !idx_err, "R9", "reset state",
            {59'd0, ready, mac_valid, unprog, wrap, idx_err}, 64'd0);
        rst_n = 1'b1;
        if (early_q) begin
            q_valid = 1'b1;
            q_index = 8'd0;
            @(negedge clk);
            q_valid = 1'b0;
            chk(!mac_valid && !idx_err, "R8", "query before ready",
                {62'd0, mac_valid, idx_err}, 64'd0);
        end
        for (int k = 0; k < 100 && !ready; k++) @(negedge clk);
        chk(ready && exp_addr == 7, "R3", "ready after seven bytes",
            {31'd0, ready, 32'(exp_addr)}, {31'd0, 1'b1, 32'd7});
        chk(!rd_req, "R3", "no request when ready", 64'(rd_req), 64'd0);
        chk(unprog == (&b), "R6", "unprogrammed flag", 64'(unprog), 64'(&b));
        chk(wrap == ((c != 0) && (9'(b[7:0]) + 9'(c) - 9'd1 > 9'h0FF)), "R7", "wrap flag",
            64'(wrap), 64'((c != 0) && (9'(b[7:0]) + 9'(c) - 9'd1 > 9'h0FF)));
    endtask

    task automatic query(input logic [7:0] idx);
        logic [47:0] e;
        q_valid = 1'b1;
        q_index = idx;
        @(negedge clk);
        q_valid = 1'b0;
        e = exp_mac(img_base(), img[6], idx);
        chk(mac_valid, "R4", "answer strobe", 64'(mac_valid), 64'd1);
        chk(mac_out == e, (idx < img[6]) ? "R4" : "R5", "address", 64'(mac_out), 64'(e));
        chk(idx_err == (idx >= img[6]), "R5", "index error", 64'(idx_err), 64'(idx >= img[6]));
        @(negedge clk);
        chk(!mac_valid && ready, "R3", "single-cycle answer, ready held",
            {62'd0, mac_valid, ready}, 64'd1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // R2 R4 R5 R8: nominal image
        load(48'h644C360F4430, 8'd8, 1'b1);
        query(8'd0);
        query(8'd3);
        query(8'd7);
        query(8'd8);
        query(8'd255);
        // R6: unprogrammed image
        load(48'hFFFFFFFFFFFF, 8'hFF, 1'b0);
        query(8'd1);
        // R7: low octet rolls over
        load(48'h0011223344F9, 8'd8, 1'b0);
        query(8'd6);
        query(8'd7);
        // R7: exactly reaches 0xFF, no wrap
        load(48'h0011223344F8, 8'd8, 1'b0);
        query(8'd7);
        // R5: zero count
        load(48'h020000000010, 8'd0, 1'b0);
        query(8'd0);
        // random images
        for (int t = 0; t < 20; t++) begin
            logic [47:0] rb;
            rb = {$urandom, $urandom};
            load(rb[47:0], 8'($urandom_range(0, 16)), 1'($urandom_range(0, 1)));
            for (int j = 0; j < 8; j++) query(8'($urandom_range(0, 20)));
        end
        finish_run();
    end
endmodule